// File: doc/BRIEF.md
# Calendar Real-Time Clock with Maskable Alarm

This block is a register-mapped calendar clock. It keeps eight separate counters: seconds, minutes, hours, day of month, day of week, day of year, month and year. An external one-second strobe advances them. Carries ripple from seconds up to the year. Month lengths follow the leap rule for years divisible by four.

Software reaches the block through a 32-bit single-cycle register bus. It can load any counter on its own or read three packed snapshot words that gather several fields at once. It programs one alarm compare value per field and a mask that drops fields from the compare. Per-field enables raise an event whenever the chosen fields change. Two sticky flags collect the alarm and increment events and drive a single interrupt line.

A typical set-time sequence clears the seconds counter first. It then loads the other fields and writes the real seconds value last, so that no carry disturbs the fields already written.

Top module: `rtc_cal_top`

## Requirements
- R1: After reset the counters read sec 0, min 0, hour 0, day-of-month 1, day-of-week 0, day-of-year 1, month 1, year 0. The control, enable and flag registers read 0, the alarm mask reads 0xFF, and `irq` is low.
- R2: The register map is as follows:
  - flags at 0x00, control at 0x08, increment enable at 0x0C, alarm mask at 0x10;
  - packed words at 0x14, 0x18 and 0x1C;
  - counters at 0x20 + 4*i and alarm values at 0x60 + 4*i, with field index i = 0 sec, 1 min, 2 hour, 3 day-of-month, 4 day-of-week, 5 day-of-year, 6 month, 7 year;
  - unmapped offsets read 0.
- R3: The counters advance by one step on a cycle with `tick` high only when control bit 0 (run) is 1 and control bit 1 (divider hold) is 0. Control bit 4 (calibration off) is stored and has no effect on counting. Control reads back only bits 0, 1 and 4.
- R4: Seconds and minutes wrap from 59 to 0 and hours wrap from 23 to 0. Each wrap carries one step into the next field.
- R5: The day carry behaves as follows:
  - day-of-week wraps from 6 to 0;
  - day-of-year wraps to 1 after 365, or after 366 when the year is divisible by 4;
  - day-of-month wraps to 1 after the month length (February has 29 days in such years), and that wrap steps the month;
  - month wraps from 12 to 1 and then steps the 12-bit year.
- R6: The packed words are read-only, and writing them changes nothing. Their layout is:
  - 0x14: sec [5:0], min [13:8], hour [20:16], day-of-week [26:24];
  - 0x18: day-of-month [4:0], month [11:8], year [27:16];
  - 0x1C: day-of-year [11:0].
- R7: Alarm mask bit i set excludes field i from the compare. Flag bit 1 sets on an advancing tick after which every unmasked field equals its alarm value and before which they did not. It sets only once per match. A mask of 0xFF never sets it.
- R8: Flag bit 0 sets on an advancing tick that changes any field whose increment-enable bit (same bit order as R2's field index) is 1.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it. A set in the same cycle wins over a clear. `irq` is high exactly when a flag bit is set.
- R10: A counter write loads the low bits of the data that fit the field: widths 6, 6, 5, 5, 3, 9, 4 and 12 for field index 0 through 7. Once seconds are written to 0, the next 59 ticks cannot carry into minutes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-second strobe, one cycle wide |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt, OR of the flag bits |

## Verification
The bench sweeps more than an hour of ticks and every month-end of one common year and one leap year against an arithmetic calendar model.
- A design with a wrong month table or leap test would land on a bad date or day-of-year after February or December.
- A design that keeps raising the alarm while a match persists would set the flag again on the tick after a clear.
- A design that ignores the mask would either fire with a mask of 0xFF or miss a combined seconds-and-hours match.

The bench also checks the seconds-first load and the read-only snapshot words. A carry leaking past the zeroed seconds, or a write landing in a snapshot word, would show as a changed minute or a changed field.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    parameter int NF = 8;    // number of calendar fields
    parameter int FW = 12;   // storage width of every field
    parameter int ABITS = 8; // byte address width

    localparam int IX_SEC = 0;
    localparam int IX_MIN = 1;
    localparam int IX_HR  = 2;
    localparam int IX_DOM = 3;
    localparam int IX_DOW = 4;
    localparam int IX_DOY = 5;
    localparam int IX_MON = 6;
    localparam int IX_YR  = 7;

    typedef logic [NF-1:0][FW-1:0] cal_t;

    typedef struct packed {
        logic caloff;
        logic divhold;
        logic run;
    } ctrl_t;

    typedef struct packed {
        cal_t             cnt;
        cal_t             alm;
        logic [NF-1:0]    mask;
        logic [NF-1:0]    incen;
        ctrl_t            ctrl;
        logic [1:0]       flags;
    } regs_t;

    function automatic logic [FW-1:0] field_mask(input logic [2:0] idx);
        case (idx)
            3'd0, 3'd1: field_mask = FW'(12'h03F);
            3'd2, 3'd3: field_mask = FW'(12'h01F);
            3'd4:       field_mask = FW'(12'h007);
            3'd5:       field_mask = FW'(12'h1FF);
            3'd6:       field_mask = FW'(12'h00F);
            default:    field_mask = FW'(12'hFFF);
        endcase
    endfunction

    function automatic logic leap(input logic [FW-1:0] yr);
        leap = (yr[1:0] == 2'b00);
    endfunction

    function automatic logic [FW-1:0] month_len(input logic [FW-1:0] mon,
                                                 input logic [FW-1:0] yr);
        case (mon)
            FW'(2):                          month_len = leap(yr) ? FW'(29) : FW'(28);
            FW'(4), FW'(6), FW'(9), FW'(11): month_len = FW'(30);
            default:                         month_len = FW'(31);
        endcase
    endfunction

endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
    import rtc_cal_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  cal_t          cur,
    output cal_t          nxt,
    output logic [NF-1:0] chg
);

    logic c_min, c_hr, c_day, c_mon, c_yr;
    logic [FW-1:0] ylen;

    always_comb begin
        nxt   = cur;
        c_min = 1'b0;
        c_hr  = 1'b0;
        c_day = 1'b0;
        c_mon = 1'b0;
        c_yr  = 1'b0;
        ylen  = leap(cur[IX_YR]) ? FW'(366) : FW'(365);
        if (adv) begin
            if (cur[IX_SEC] >= FW'(59)) begin
                nxt[IX_SEC] = '0;
                c_min       = 1'b1;
            end else begin
                nxt[IX_SEC] = cur[IX_SEC] + FW'(1);
            end
            if (c_min) begin
                if (cur[IX_MIN] >= FW'(59)) begin
                    nxt[IX_MIN] = '0;
                    c_hr        = 1'b1;
                end else begin
                    nxt[IX_MIN] = cur[IX_MIN] + FW'(1);
                end
            end
            if (c_hr) begin
                if (cur[IX_HR] >= FW'(23)) begin
                    nxt[IX_HR] = '0;
                    c_day      = 1'b1;
                end else begin
                    nxt[IX_HR] = cur[IX_HR] + FW'(1);
                end
            end
            if (c_day) begin
                nxt[IX_DOW] = (cur[IX_DOW] >= FW'(6)) ? '0 : cur[IX_DOW] + FW'(1);
                nxt[IX_DOY] = (cur[IX_DOY] >= ylen) ? FW'(1) : cur[IX_DOY] + FW'(1);
                if (cur[IX_DOM] >= month_len(cur[IX_MON], cur[IX_YR])) begin
                    nxt[IX_DOM] = FW'(1);
                    c_mon       = 1'b1;
                end else begin
                    nxt[IX_DOM] = cur[IX_DOM] + FW'(1);
                end
            end
            if (c_mon) begin
                if (cur[IX_MON] >= FW'(12)) begin
                    nxt[IX_MON] = FW'(1);
                    c_yr        = 1'b1;
                end else begin
                    nxt[IX_MON] = cur[IX_MON] + FW'(1);
                end
            end
            if (c_yr) begin
                nxt[IX_YR] = cur[IX_YR] + FW'(1);
            end
        end
    end

    for (genvar g = 0; g < NF; g++) begin : g_chg
        assign chg[g] = (nxt[g] != cur[g]);
    end

    AST_MON_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cur[IX_MON] >= FW'(1) && cur[IX_MON] <= FW'(12))
            |-> (nxt[IX_MON] >= FW'(1) && nxt[IX_MON] <= FW'(12))); // R5

endmodule

// File: rtl/rtc_cal_alarm.sv
module rtc_cal_alarm
    import rtc_cal_pkg::*;
(
    input  logic          adv,
    input  cal_t          cur,
    input  cal_t          nxt,
    input  cal_t          alm,
    input  logic [NF-1:0] mask,
    output logic          hit
);

    logic [NF-1:0] eq_cur;
    logic [NF-1:0] eq_nxt;

    for (genvar g = 0; g < NF; g++) begin : g_cmp
        assign eq_cur[g] = mask[g] || (cur[g] == alm[g]);
        assign eq_nxt[g] = mask[g] || (nxt[g] == alm[g]);
    end

    assign hit = adv && !(&mask) && (&eq_nxt) && !(&eq_cur);

endmodule

// File: rtl/rtc_cal_top.sv
module rtc_cal_top
    import rtc_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             bus_wr,
    input  logic [ABITS-1:0] bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             irq
);

    localparam logic [ABITS-1:0] A_FLAG = ABITS'(8'h00);
    localparam logic [ABITS-1:0] A_CTRL = ABITS'(8'h08);
    localparam logic [ABITS-1:0] A_INCE = ABITS'(8'h0C);
    localparam logic [ABITS-1:0] A_MASK = ABITS'(8'h10);
    localparam logic [ABITS-1:0] A_PK0  = ABITS'(8'h14);
    localparam logic [ABITS-1:0] A_PK1  = ABITS'(8'h18);
    localparam logic [ABITS-1:0] A_PK2  = ABITS'(8'h1C);

    regs_t q, d;

    logic          adv;
    cal_t          step_nxt;
    logic [NF-1:0] step_chg;
    logic          alarm_hit;
    logic          cnt_sel, alm_sel, cnt_wr;
    logic [2:0]    fidx;
    logic          unused_wdata;

    assign adv     = tick && q.ctrl.run && !q.ctrl.divhold;
    assign fidx    = bus_addr[4:2];
    assign cnt_sel = (bus_addr[7:5] == 3'b001) && (bus_addr[1:0] == 2'b00);
    assign alm_sel = (bus_addr[7:5] == 3'b011) && (bus_addr[1:0] == 2'b00);
    assign cnt_wr  = bus_wr && cnt_sel;
    assign unused_wdata = ^bus_wdata[31:FW];

    rtc_cal_step u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .cur   (q.cnt),
        .nxt   (step_nxt),
        .chg   (step_chg)
    );

    rtc_cal_alarm u_alarm (
        .adv   (adv),
        .cur   (q.cnt),
        .nxt   (step_nxt),
        .alm   (q.alm),
        .mask  (q.mask),
        .hit   (alarm_hit)
    );

    always_comb begin
        d     = q;
        d.cnt = step_nxt;
        if (bus_wr) begin
            if (cnt_sel) begin
                d.cnt[fidx] = bus_wdata[FW-1:0] & field_mask(fidx);
            end else if (alm_sel) begin
                d.alm[fidx] = bus_wdata[FW-1:0] & field_mask(fidx);
            end else if (bus_addr == A_CTRL) begin
                d.ctrl = '{caloff: bus_wdata[4], divhold: bus_wdata[1], run: bus_wdata[0]};
            end else if (bus_addr == A_INCE) begin
                d.incen = bus_wdata[NF-1:0];
            end else if (bus_addr == A_MASK) begin
                d.mask = bus_wdata[NF-1:0];
            end else if (bus_addr == A_FLAG) begin
                d.flags = q.flags & ~bus_wdata[1:0];
            end
        end
        if (adv && |(step_chg & q.incen)) begin
            d.flags[0] = 1'b1;
        end
        if (alarm_hit) begin
            d.flags[1] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt            <= '0;
            q.cnt[IX_DOM]    <= FW'(1);
            q.cnt[IX_DOY]    <= FW'(1);
            q.cnt[IX_MON]    <= FW'(1);
            q.alm            <= '0;
            q.mask           <= '1;
            q.incen          <= '0;
            q.ctrl           <= '0;
            q.flags          <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (cnt_sel) begin
            bus_rdata[FW-1:0] = q.cnt[fidx];
        end else if (alm_sel) begin
            bus_rdata[FW-1:0] = q.alm[fidx];
        end else begin
            case (bus_addr)
                A_FLAG:  bus_rdata[1:0] = q.flags;
                A_CTRL:  bus_rdata = {27'd0, q.ctrl.caloff, 2'b00, q.ctrl.divhold, q.ctrl.run};
                A_INCE:  bus_rdata[NF-1:0] = q.incen;
                A_MASK:  bus_rdata[NF-1:0] = q.mask;
                A_PK0:   bus_rdata = {5'd0, q.cnt[IX_DOW][2:0], 3'd0, q.cnt[IX_HR][4:0],
                                      2'd0, q.cnt[IX_MIN][5:0], 2'd0, q.cnt[IX_SEC][5:0]};
                A_PK1:   bus_rdata = {4'd0, q.cnt[IX_YR][11:0], 4'd0, q.cnt[IX_MON][3:0],
                                      3'd0, q.cnt[IX_DOM][4:0]};
                A_PK2:   bus_rdata = {20'd0, q.cnt[IX_DOY][11:0]};
                default: bus_rdata = '0;
            endcase
        end
    end

    assign irq = |q.flags;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !cnt_wr) |=> $stable(q.cnt)); // R3

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !cnt_wr && q.cnt[IX_SEC] == FW'(59)) |=> (q.cnt[IX_SEC] == '0)); // R4

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mask == '1) |=> !$rose(q.flags[1])); // R7

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(adv)); // R9

    AST_RO_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !adv && (bus_addr == A_PK0 || bus_addr == A_PK1 || bus_addr == A_PK2))
            |=> $stable(q)); // R6

endmodule

// File: tb/rtc_cal_top_test.sv
module rtc_cal_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_s, m_mi, m_h, m_dm, m_dw, m_dy, m_mo, m_y;

    always #4 clk = ~clk;

    rtc_cal_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic int mdays(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic int ydays(int y);
        return (y % 4 == 0) ? 366 : 365;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = v;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic m_step();
        m_s++;
        if (m_s == 60) begin
            m_s = 0; m_mi++;
            if (m_mi == 60) begin
                m_mi = 0; m_h++;
                if (m_h == 24) begin
                    m_h  = 0;
                    m_dw = (m_dw + 1) % 7;
                    m_dy = (m_dy == ydays(m_y)) ? 1 : m_dy + 1;
                    if (m_dm == mdays(m_mo, m_y)) begin
                        m_dm = 1;
                        if (m_mo == 12) begin
                            m_mo = 1;
                            m_y  = (m_y + 1) % 4096;
                        end else begin
                            m_mo++;
                        end
                    end else begin
                        m_dm++;
                    end
                end
            end
        end
    endtask

    task automatic do_tick(input bit model);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        if (model) m_step();
    endtask

    task automatic cmp_time(input string req);
        logic [31:0] v;
        rd(8'h20, v); chk({req, " sec"},  v, m_s);
        rd(8'h24, v); chk({req, " min"},  v, m_mi);
        rd(8'h28, v); chk({req, " hour"}, v, m_h);
        rd(8'h2C, v); chk({req, " dom"},  v, m_dm);
        rd(8'h30, v); chk({req, " dow"},  v, m_dw);
        rd(8'h34, v); chk({req, " doy"},  v, m_dy);
        rd(8'h38, v); chk({req, " mon"},  v, m_mo);
        rd(8'h3C, v); chk({req, " year"}, v, m_y);
    endtask

    task automatic set_time(input int y, input int mo, input int dm, input int dw,
                            input int dy, input int h, input int mi, input int s);
        wr(8'h20, 0);
        wr(8'h3C, y); wr(8'h38, mo); wr(8'h2C, dm); wr(8'h30, dw);
        wr(8'h34, dy); wr(8'h28, h); wr(8'h24, mi); wr(8'h20, s);
        m_y = y; m_mo = mo; m_dm = dm; m_dw = dw; m_dy = dy; m_h = h; m_mi = mi; m_s = s;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v0, v1, v2;
        int cum;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2: reset state through the register map
        m_y = 0; m_mo = 1; m_dm = 1; m_dw = 0; m_dy = 1; m_h = 0; m_mi = 0; m_s = 0;
        cmp_time("R1 reset");
        rd(8'h00, v); chk("R1 flags", v, 0);
        rd(8'h08, v); chk("R1 ctrl", v, 0);
        rd(8'h0C, v); chk("R1 incen", v, 0);
        rd(8'h10, v); chk("R1 mask", v, 32'hFF);
        chk("R1 irq", irq, 0);
        rd(8'h44, v); chk("R2 unmapped", v, 0);
        wr(8'h64, 32'h2A); rd(8'h64, v); chk("R2 alarm min reg", v, 32'h2A);

        // R3: gating of counting
        do_tick(0); do_tick(0);
        rd(8'h20, v); chk("R3 stopped", v, 0);
        wr(8'h08, 32'h3);
        do_tick(0);
        rd(8'h20, v); chk("R3 divider hold", v, 0);
        wr(8'h08, 32'hFF);
        rd(8'h08, v); chk("R3 ctrl readback", v, 32'h13);
        wr(8'h08, 32'h11);
        do_tick(1);
        rd(8'h20, v); chk("R3 running with cal off", v, 1);
        wr(8'h08, 32'h1);

        // R4: sweep over more than an hour
        set_time(2024, 3, 10, 2, 70, 22, 58, 30);
        for (int i = 0; i < 3700; i++) begin
            do_tick(1);
            cmp_time("R4 sweep");
        end

        // R5: every month end in a common and a leap year
        for (int y = 2023; y <= 2024; y++) begin
            cum = 0;
            for (int mo = 1; mo <= 12; mo++) begin
                cum += mdays(mo, y);
                set_time(y, mo, mdays(mo, y), mo % 7, cum, 23, 59, 58);
                for (int k = 0; k < 3; k++) begin
                    do_tick(1);
                    cmp_time("R5 month end");
                end
            end
        end

        // R6: packed words and their read-only behaviour
        set_time(2024, 7, 19, 5, 201, 13, 45, 27);
        rd(8'h14, v0); chk("R6 word0", v0, (5 << 24) | (13 << 16) | (45 << 8) | 27);
        rd(8'h18, v1); chk("R6 word1", v1, (2024 << 16) | (7 << 8) | 19);
        rd(8'h1C, v2); chk("R6 word2", v2, 201);
        wr(8'h14, 32'hFFFFFFFF); wr(8'h18, 32'hFFFFFFFF); wr(8'h1C, 32'hFFFFFFFF);
        rd(8'h14, v); chk("R6 word0 after write", v, v0);
        rd(8'h18, v); chk("R6 word1 after write", v, v1);
        rd(8'h1C, v); chk("R6 word2 after write", v, v2);
        cmp_time("R6 counters after write");

        // R7: alarm on seconds only
        wr(8'h60, 5); wr(8'h68, 1);
        wr(8'h10, 32'hFE);
        set_time(2024, 1, 1, 1, 1, 0, 0, 0);
        wr(8'h00, 3);
        for (int i = 0; i < 4; i++) do_tick(1);
        rd(8'h00, v); chk("R7 before match", v[1], 0);
        do_tick(1);
        rd(8'h00, v); chk("R7 sec match", v[1], 1);
        chk("R9 irq on alarm", irq, 1);
        wr(8'h00, 2);
        do_tick(1);
        rd(8'h00, v); chk("R7 after sec match", v[1], 0);
        // hours only: fires once while the match lasts
        wr(8'h10, 32'hFB);
        set_time(2024, 1, 1, 1, 1, 0, 59, 59);
        wr(8'h00, 3);
        do_tick(1);
        rd(8'h00, v); chk("R7 hour match", v[1], 1);
        wr(8'h00, 2);
        do_tick(1);
        rd(8'h00, v); chk("R7 fires once", v[1], 0);
        // seconds and hours together
        wr(8'h10, 32'hFA);
        set_time(2024, 1, 1, 1, 1, 0, 59, 59);
        wr(8'h00, 3);
        do_tick(1);
        rd(8'h00, v); chk("R7 partial match", v[1], 0);
        for (int i = 0; i < 5; i++) do_tick(1);
        rd(8'h00, v); chk("R7 combined match", v[1], 1);
        // everything masked
        wr(8'h10, 32'hFF);
        set_time(2024, 1, 1, 1, 1, 0, 59, 59);
        wr(8'h00, 3);
        for (int i = 0; i < 7; i++) do_tick(1);
        rd(8'h00, v); chk("R7 all masked", v[1], 0);

        // R8: increment events
        wr(8'h0C, 32'h02);
        set_time(2024, 1, 1, 1, 1, 4, 10, 58);
        wr(8'h00, 3);
        do_tick(1);
        rd(8'h00, v); chk("R8 no minute change", v[0], 0);
        do_tick(1);
        rd(8'h00, v); chk("R8 minute change", v[0], 1);
        wr(8'h0C, 32'h00); wr(8'h00, 3);
        for (int i = 0; i < 61; i++) do_tick(1);
        rd(8'h00, v); chk("R8 none enabled", v[0], 0);
        wr(8'h0C, 32'h80);
        set_time(2024, 12, 31, 1, 366, 23, 59, 59);
        wr(8'h00, 3);
        do_tick(1);
        rd(8'h00, v); chk("R8 year change", v[0], 1);
        cmp_time("R5 leap year end");

        // R9: write-one-to-clear per bit
        wr(8'h0C, 32'h01);
        wr(8'h10, 32'hFE);
        set_time(2024, 1, 1, 1, 1, 0, 0, 20);
        wr(8'h60, 21);
        wr(8'h00, 3);
        do_tick(1);
        rd(8'h00, v); chk("R9 both set", v, 3);
        wr(8'h00, 1);
        rd(8'h00, v); chk("R9 clear bit0 only", v, 2);
        chk("R9 irq held", irq, 1);
        wr(8'h00, 0);
        rd(8'h00, v); chk("R9 write zero keeps", v, 2);
        wr(8'h00, 2);
        rd(8'h00, v); chk("R9 all clear", v, 0);
        chk("R9 irq low", irq, 0);
        wr(8'h0C, 0); wr(8'h10, 32'hFF);

        // R10: zeroed seconds block the carry; write widths
        wr(8'h24, 10); wr(8'h20, 59);
        wr(8'h20, 0);
        do_tick(0);
        rd(8'h24, v); chk("R10 no carry", v, 10);
        rd(8'h20, v); chk("R10 seconds from zero", v, 1);
        wr(8'h30, 32'hFFFFFFFF); rd(8'h30, v); chk("R10 dow width", v, 7);
        wr(8'h20, 32'hFFFFFFFF); rd(8'h20, v); chk("R10 sec width", v, 63);
        wr(8'h34, 32'hFFFFFFFF); rd(8'h34, v); chk("R10 doy width", v, 511);
        wr(8'h3C, 32'hFFFFFFFF); rd(8'h3C, v); chk("R10 year width", v, 4095);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule